// File: doc/BRIEF.md
# VBI Ancillary Packet Formatter

This block wraps the sliced vertical-blanking payload of one video line into a self-describing ancillary packet and streams it out a byte per cycle. The packet goes out during the horizontal blanking that follows the line the data came from, and the same byte stream can be written into a byte FIFO. Line timing, slicing, error detection and the FIFO itself sit outside the block.

A timing controller pulses `pkt_start` at the start of blanking. On that pulse the block captures the line descriptor: the field, whether the line is at or after line 24, a 6-bit format code, the 10-bit line number, two match flags, an error flag and the payload length in bytes. It then emits a three-byte preamble, a parity-protected header, the payload, a running 8-bit checksum and fill bytes that round the packet up to a 4-byte boundary. Payload bytes are pulled from a show-ahead source: `pay_rd` is high in each cycle where `pay_data` is consumed.

Top module: `vbi_anc_packer`

## Requirements
- R1: After reset, and whenever no packet is in progress, `out_valid`, `out_last` and `pay_rd` are 0. A `pkt_start` seen while idle makes `out_valid` high from the next cycle. Bytes 0, 1 and 2 of the packet are 00h, FFh and FFh.
- R2: Bytes 3, 4 and 5 each carry a 6-bit value v in bits 5:0. Bit 6 is the XOR of v's bits, and bit 7 is the inverse of bit 6.
- R3: The 6-bit value of byte 3 is {3'b010, field, after24, 1'b1}, which gives a full byte of 91h for field 0 before line 24, 53h for field 0 from line 24, 55h for field 1 before line 24, and 97h for field 1 from line 24.
- R4: The 6-bit value of byte 4 is the captured format code.
- R5: The 6-bit value of byte 5 is the number of 4-byte words from byte 8 to the end of the packet, (len+4)/4. Lengths above 251 are not allowed.
- R6: Byte 6 is line bits 7:0. Byte 7 is {3'b000, err, match1, match2, line[9:8]}, so the error flag is bit 4, match1 bit 3, match2 bit 2 and line[9:8] bits 1:0.
- R7: Bytes 8 to 7+len are the payload bytes in arrival order, one per cycle with no gaps. `pay_rd` is high for exactly those len cycles.
- R8: The byte right after the payload is the modulo-256 sum of bytes 3 through the last payload byte. The preamble is not included in the sum.
- R9: Fill bytes of value FILL_BYTE (80h by default) follow the checksum until the packet length is a multiple of 4. `out_last` marks the final byte.
- R10: `pkt_start` and descriptor changes while a packet is in progress have no effect on that packet. `out_valid` drops in the cycle after `out_last`.
- R11: A zero-length payload yields a 12-byte packet: eight header bytes, the checksum, then three fill bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_start | input | 1 | Begin a packet; the descriptor is captured when this is high while idle |
| field_i | input | 1 | Field of the source line (0 first, 1 second) |
| after24_i | input | 1 | Source line is at or after line 24 |
| fmt_i | input | 6 | Data format code of the line |
| line_i | input | 10 | Source line number |
| match1_i | input | 1 | Match 1 flag |
| match2_i | input | 1 | Match 2 flag |
| err_i | input | 1 | Error-detected flag |
| len_i | input | LEN_W | Payload length in bytes |
| pay_data | input | 8 | Show-ahead payload byte |
| pay_rd | output | 1 | Payload byte consumed this cycle |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final byte of the packet |

## Verification
The assertions assume that `len_i` is at most 251 whenever a packet starts. They also assume that `pay_data` always presents the next payload byte, so the block never has to wait for one. The stimulus meets both conditions. It sweeps lengths from 0 to 19 plus the largest legal ones, and every combination of field and line range. Payload bytes come from a counter-driven formula that never stalls. Mid-packet start pulses that carry a different length are injected while a packet is in progress, to show that they leave the stream unchanged.

// File: rtl/vbi_anc_pkg.sv
package vbi_anc_pkg;

  localparam int unsigned NN_W = 6;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HEAD,
    ST_DATA,
    ST_CSUM,
    ST_FILL
  } anc_state_e;

  // six-bit value with even-parity bit and its complement on top
  function automatic logic [7:0] anc_protect(input logic [5:0] v);
    return {~(^v), ^v, v};
  endfunction

endpackage

// File: rtl/anc_hdr.sv
module anc_hdr
  import vbi_anc_pkg::*;
#(
  parameter int unsigned LEN_W = 8
) (
  input  logic             field_i,
  input  logic             after24_i,
  input  logic [5:0]       fmt_i,
  input  logic [9:0]       line_i,
  input  logic             match1_i,
  input  logic             match2_i,
  input  logic             err_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [2:0]       idx_i,
  output logic [7:0]       byte_o
);

  logic [LEN_W:0] words;
  logic [5:0]     did_v;

  always_comb begin
    words = ({1'b0, len_i} + (LEN_W+1)'(4)) >> 2;
    did_v = {3'b010, field_i, after24_i, 1'b1};
    case (idx_i)
      3'd0:    byte_o = 8'h00;
      3'd1:    byte_o = 8'hFF;
      3'd2:    byte_o = 8'hFF;
      3'd3:    byte_o = anc_protect(did_v);
      3'd4:    byte_o = anc_protect(fmt_i);
      3'd5:    byte_o = anc_protect(words[NN_W-1:0]);
      3'd6:    byte_o = line_i[7:0];
      default: byte_o = {3'b000, err_i, match1_i, match2_i, line_i[9:8]};
    endcase
  end

endmodule

// File: rtl/anc_seq.sv
module anc_seq
  import vbi_anc_pkg::*;
#(
  parameter int unsigned LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  output anc_state_e       state_o,
  output logic [LEN_W-1:0] cnt_o,
  output logic             last_o
);

  localparam logic [LEN_W-1:0] HEAD_END = LEN_W'(7);
  localparam logic [LEN_W-1:0] ONE      = LEN_W'(1);

  anc_state_e       state_q, state_d;
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic [1:0]       fill_n;
  logic [LEN_W-1:0] fill_end;

  assign fill_n   = ~len_i[1:0];
  assign fill_end = LEN_W'(fill_n - 2'd1);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_HEAD;
        cnt_d   = '0;
      end
      ST_HEAD: begin
        if (cnt_q == HEAD_END) begin
          state_d = (len_i == '0) ? ST_CSUM : ST_DATA;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + ONE;
        end
      end
      ST_DATA: begin
        if (cnt_q == len_i - ONE) begin
          state_d = ST_CSUM;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + ONE;
        end
      end
      ST_CSUM: begin
        state_d = (fill_n == 2'd0) ? ST_IDLE : ST_FILL;
        cnt_d   = '0;
      end
      ST_FILL: begin
        if (cnt_q == fill_end) begin
          state_d = ST_IDLE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + ONE;
        end
      end
      default: begin
        state_d = ST_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state_o = state_q;
  assign cnt_o   = cnt_q;
  assign last_o  = ((state_q == ST_CSUM) && (fill_n == 2'd0)) ||
                   ((state_q == ST_FILL) && (cnt_q == fill_end));

  // R10: once a packet is running, the state machine never jumps back into the header
  p_no_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && state_q != ST_HEAD) |=> (state_q != ST_HEAD));

endmodule

// File: rtl/anc_csum.sv
module anc_csum (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear_i,
  input  logic       add_i,
  input  logic [7:0] byte_i,
  output logic [7:0] sum_o
);

  logic [7:0] sum_q, sum_d;
  logic       sum_en;

  assign sum_en = clear_i | add_i;

  always_comb begin
    if (clear_i) sum_d = 8'h00;
    else         sum_d = sum_q + byte_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sum_q <= 8'h00;
    else if (sum_en) sum_q <= sum_d;
  end

  assign sum_o = sum_q;

endmodule

// File: rtl/vbi_anc_packer.sv
module vbi_anc_packer
  import vbi_anc_pkg::*;
#(
  parameter int unsigned LEN_W     = 8,
  parameter logic [7:0]  FILL_BYTE = 8'h80
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pkt_start,
  input  logic             field_i,
  input  logic             after24_i,
  input  logic [5:0]       fmt_i,
  input  logic [9:0]       line_i,
  input  logic             match1_i,
  input  logic             match2_i,
  input  logic             err_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [7:0]       pay_data,
  output logic             pay_rd,
  output logic             out_valid,
  output logic [7:0]       out_data,
  output logic             out_last
);

  localparam int unsigned MAX_LEN  = 4 * ((1 << NN_W) - 1) - 1;
  localparam logic [LEN_W-1:0] SUM_FROM = LEN_W'(3);

  anc_state_e       state;
  logic [LEN_W-1:0] cnt;
  logic             load;
  logic [7:0]       hdr_byte, sum;
  logic             sum_add;

  // captured descriptor
  logic             field_q, after24_q, match1_q, match2_q, err_q;
  logic [5:0]       fmt_q;
  logic [9:0]       line_q;
  logic [LEN_W-1:0] len_q;

  assign load = pkt_start && (state == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      field_q   <= 1'b0;
      after24_q <= 1'b0;
      match1_q  <= 1'b0;
      match2_q  <= 1'b0;
      err_q     <= 1'b0;
      fmt_q     <= '0;
      line_q    <= '0;
      len_q     <= '0;
    end else if (load) begin
      field_q   <= field_i;
      after24_q <= after24_i;
      match1_q  <= match1_i;
      match2_q  <= match2_i;
      err_q     <= err_i;
      fmt_q     <= fmt_i;
      line_q    <= line_i;
      len_q     <= len_i;
    end
  end

  anc_seq #(.LEN_W(LEN_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (pkt_start),
    .len_i   (len_q),
    .state_o (state),
    .cnt_o   (cnt),
    .last_o  (out_last)
  );

  anc_hdr #(.LEN_W(LEN_W)) u_hdr (
    .field_i   (field_q),
    .after24_i (after24_q),
    .fmt_i     (fmt_q),
    .line_i    (line_q),
    .match1_i  (match1_q),
    .match2_i  (match2_q),
    .err_i     (err_q),
    .len_i     (len_q),
    .idx_i     (cnt[2:0]),
    .byte_o    (hdr_byte)
  );

  assign sum_add = ((state == ST_HEAD) && (cnt >= SUM_FROM)) || (state == ST_DATA);

  anc_csum u_csum (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (load),
    .add_i   (sum_add),
    .byte_i  (out_data),
    .sum_o   (sum)
  );

  always_comb begin
    case (state)
      ST_HEAD: out_data = hdr_byte;
      ST_DATA: out_data = pay_data;
      ST_CSUM: out_data = sum;
      ST_FILL: out_data = FILL_BYTE;
      default: out_data = 8'h00;
    endcase
  end

  assign out_valid = (state != ST_IDLE);
  assign pay_rd    = (state == ST_DATA);

  // checker counter: bytes emitted in the current packet, modulo 4
  logic [1:0] chk_bytes_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         chk_bytes_q <= 2'd0;
    else if (load)      chk_bytes_q <= 2'd0;
    else if (out_valid) chk_bytes_q <= chk_bytes_q + 2'd1;
  end

  p_last_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  p_quad_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> (chk_bytes_q == 2'd3));

  p_idle_after_last_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |=> !out_valid);

  p_rd_in_pkt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pay_rd |-> out_valid);

  p_hold_desc_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> $stable(len_q) && $stable(line_q) && $stable(fmt_q));

  p_len_max_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (int'(len_i) <= MAX_LEN));

  p_hdr_parity_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_HEAD) && (cnt >= SUM_FROM) && (cnt < LEN_W'(6))) |->
      ((out_data[6] == ^out_data[5:0]) && (out_data[7] != out_data[6])));

endmodule

// File: tb/vbi_anc_packer_test.sv
`timescale 1ns/1ps
module vbi_anc_packer_test;

  localparam int LEN_W = 8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             pkt_start;
  logic             field_i, after24_i, match1_i, match2_i, err_i;
  logic [5:0]       fmt_i;
  logic [9:0]       line_i;
  logic [LEN_W-1:0] len_i;
  logic [7:0]       pay_data;
  logic             pay_rd, out_valid, out_last;
  logic [7:0]       out_data;

  int checks = 0;
  int errors = 0;

  logic [8:0] pidx;
  logic       pclr;
  logic [7:0] seed;

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    if (pclr)        pidx <= '0;
    else if (pay_rd) pidx <= pidx + 9'd1;
  end

  assign pay_data = seed ^ 8'(pidx * 37 + 11);

  vbi_anc_packer #(.LEN_W(LEN_W), .FILL_BYTE(8'h80)) uut (
    .clk(clk), .rst_n(rst_n), .pkt_start(pkt_start),
    .field_i(field_i), .after24_i(after24_i), .fmt_i(fmt_i), .line_i(line_i),
    .match1_i(match1_i), .match2_i(match2_i), .err_i(err_i), .len_i(len_i),
    .pay_data(pay_data), .pay_rd(pay_rd), .out_valid(out_valid),
    .out_data(out_data), .out_last(out_last)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] prot(input logic [5:0] v);
    return {~(^v), ^v, v};
  endfunction

  function automatic string req_of(input int i, input int len);
    if (i < 3) return "R1 preamble";
    if (i == 3) return "R3 DID";
    if (i == 4) return "R4 SDID";
    if (i == 5) return "R5 NN";
    if (i < 8) return "R6 line/status";
    if (i < 8 + len) return "R7 payload";
    if (i == 8 + len) return "R8 checksum";
    return "R9 fill";
  endfunction

  task automatic run_pkt(input int len, input logic fld, input logic a24,
                         input logic [5:0] fmt, input logic [9:0] line,
                         input logic m1, input logic m2, input logic er,
                         input logic [7:0] sd, input bit disturb);
    logic [7:0] exp [0:263];
    int n;
    logic [7:0] s;
    n = ((9 + len + 3) / 4) * 4;
    exp[0] = 8'h00; exp[1] = 8'hFF; exp[2] = 8'hFF;
    exp[3] = prot({3'b010, fld, a24, 1'b1});
    exp[4] = prot(fmt);
    exp[5] = prot(6'((len + 4) / 4));
    exp[6] = line[7:0];
    exp[7] = {3'b000, er, m1, m2, line[9:8]};
    for (int k = 0; k < len; k++) exp[8 + k] = sd ^ 8'(k * 37 + 11);
    s = 8'h00;
    for (int k = 3; k < 8 + len; k++) s = s + exp[k];
    exp[8 + len] = s;
    for (int k = 9 + len; k < n; k++) exp[k] = 8'h80;

    seed = sd;
    field_i = fld; after24_i = a24; fmt_i = fmt; line_i = line;
    match1_i = m1; match2_i = m2; err_i = er; len_i = LEN_W'(len);
    pkt_start = 1'b1; pclr = 1'b1;
    @(negedge clk);
    pkt_start = 1'b0; pclr = 1'b0;
    for (int i = 0; i < n; i++) begin
      check("R1 valid in packet", out_valid, 1'b1);
      check(req_of(i, len), out_data, exp[i]);
      check("R9 last marker", out_last, (i == n - 1));
      if (disturb && i == 4) begin
        // R10: start pulse and altered descriptor while busy
        pkt_start = 1'b1; len_i = LEN_W'(len ^ 5); line_i = ~line; fmt_i = ~fmt;
      end else begin
        pkt_start = 1'b0;
      end
      @(negedge clk);
    end
    pkt_start = 1'b0;
    check("R10 idle after last", out_valid, 1'b0);
    check("R7 payload read count", pidx, 9'(len));
    if (len == 0) check("R11 zero-length size", n, 12);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pkt_start = 1'b0; pclr = 1'b1; seed = 8'h00;
    field_i = 0; after24_i = 0; fmt_i = '0; line_i = '0;
    match1_i = 0; match2_i = 0; err_i = 0; len_i = '0;
    repeat (3) @(negedge clk);
    check("R1 reset valid", out_valid, 1'b0);
    check("R1 reset last", out_last, 1'b0);
    check("R1 reset pay_rd", pay_rd, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    pclr = 1'b0;
    check("R1 idle valid", out_valid, 1'b0);
    for (int l = 0; l < 20; l++) begin
      for (int c = 0; c < 4; c++) begin
        run_pkt(l, c[1], c[0], 6'((l * 5 + c * 11) & 63), 10'(6 + l * 41 + c * 7),
                (l + c) % 2 == 0, c % 3 == 1, l % 3 == 2, 8'(l * 13 + c), (l % 4 == c));
        @(negedge clk);
      end
    end
    run_pkt(251, 1'b1, 1'b1, 6'h3F, 10'h3FF, 1, 1, 1, 8'hA5, 1);
    run_pkt(251, 1'b0, 1'b0, 6'h00, 10'h000, 0, 0, 0, 8'h5A, 0);
    run_pkt(250, 1'b1, 1'b0, 6'h2A, 10'h2AA, 1, 0, 1, 8'h3C, 0);
    run_pkt(248, 1'b0, 1'b1, 6'h15, 10'h155, 0, 1, 0, 8'hC3, 1);
    // back-to-back: start on the first idle cycle
    run_pkt(3, 1'b0, 1'b0, 6'h01, 10'd6, 0, 0, 0, 8'h11, 0);
    run_pkt(0, 1'b1, 1'b0, 6'h02, 10'd27, 1, 1, 0, 8'h22, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule